// File: doc/BRIEF.md
# Nibble-Mode Reverse Data Receiver

This block is the host side of a reverse-channel transfer on a parallel peripheral port, for use once the port has agreed to send data back to the host four bits at a time. After a start pulse with a byte count, it asks the peripheral for each half-byte by pulling the auto-feed line low. It waits for the peripheral to pull the acknowledge line low, then takes four bits from the status lines. It releases auto-feed and waits for acknowledge to return high. Two such half-byte exchanges make one byte, low half first. The byte is then offered on a valid/ready stream.

Every wait is bounded. The wait for the first half of a byte gets a long idle window. The wait for the second half and every wait for acknowledge to go high get a short response window. Both windows are counted in ticks of a fixed number of clock cycles. A run stops on the first expired window and reports why. A run also reports how many bytes the consumer accepted. While an offered byte is still waiting for the consumer, no new half-byte is requested.

Top module: `nib_rev_rx`

## Requirements
- R1: After reset the auto-feed output is high, the byte stream is not valid, busy is low and the delivered count is 0.
- R2: A start pulse while idle with a nonzero count drives auto-feed low on the next cycle. A start pulse while a run is active has no effect on that run.
- R3: While auto-feed is low and acknowledge is seen low, the block captures the half-byte with nFault to bit 0, Select to bit 1, PError to bit 2 and Busy to bit 3. It raises auto-feed one cycle later.
- R4: The first half-byte of a byte forms bits 3:0 and the second forms bits 7:4. The byte becomes valid only after acknowledge has returned high following the second half-byte.
- R5: While valid is high and ready is low, valid stays high and the data stays stable.
- R6: Auto-feed is never low while an offered byte has not been accepted.
- R7: The wait for the first half-byte lasts LONG_TICKS*TICK_CYCLES cycles. The wait for the second half-byte lasts SHORT_TICKS*TICK_CYCLES cycles. If either window expires, the run ends with status 1 (timeout).
- R8: If acknowledge does not return high within SHORT_TICKS*TICK_CYCLES cycles, the run ends with status 1 after a first half-byte and with status 2 (I/O error) after a second half-byte.
- R9: A run ends with a one-cycle done pulse. After all requested bytes are accepted the status is 0 (success), and a zero count finishes at once with status 0. The delivered count equals the number of bytes the consumer accepted.
- R10: When a run ends, auto-feed is high, busy is low and no byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a run |
| req_count_i | input | CNT_W | Number of bytes to receive |
| ack_n_i | input | 1 | Synchronised acknowledge line, active low |
| busy_i | input | 1 | Synchronised Busy status line |
| perror_i | input | 1 | Synchronised paper-error status line |
| select_i | input | 1 | Synchronised Select status line |
| fault_n_i | input | 1 | Synchronised fault line, active low |
| autofd_n_o | output | 1 | Auto-feed line, low requests a half-byte |
| byte_valid_o | output | 1 | Assembled byte is offered |
| byte_data_o | output | 8 | Assembled byte |
| byte_ready_i | input | 1 | Consumer accepts the offered byte |
| busy_o | output | 1 | A run is active |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| status_o | output | 2 | End status: 0 success, 1 timeout, 2 I/O error |
| delivered_o | output | CNT_W | Bytes accepted in the current or last run |

## Verification
The hardest cases to reach are the four distinct ways a run can be cut short. Each one depends on which handshake phase the peripheral stops in and on which half of the byte is in flight. The bench drives a scripted peripheral model that can stop at any chosen phase. It measures from the port how many cycles pass between the last request edge and the done pulse, and compares that against the long and short windows. Random runs mix first-half delays longer than the short window with a consumer that stalls often. This shows that the long window applies only to the first half of a byte, and that requests stop while a byte waits for the consumer.

// File: rtl/nib_rx_pkg.sv
package nib_rx_pkg;

  typedef enum logic [1:0] {
    RX_OK      = 2'd0,
    RX_TIMEOUT = 2'd1,
    RX_IOERR   = 2'd2
  } rx_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_ACK  = 2'd2,
    S_HOLD = 2'd3
  } rx_state_e;

  // Status lines to half-byte: fault_n -> b0, select -> b1, perror -> b2, busy -> b3
  function automatic logic [3:0] lines_to_nibble(input logic fault_n, input logic select,
                                                 input logic perror, input logic busy);
    return {busy, perror, select, fault_n};
  endfunction

  function automatic logic [7:0] join_nibbles(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

  function automatic int unsigned window_cycles(input int unsigned ticks, input int unsigned per_tick);
    return ticks * per_tick;
  endfunction

endpackage

// File: rtl/nib_rx_timer.sv
module nib_rx_timer #(
  parameter int unsigned LONG_CYC  = 8000,
  parameter int unsigned SHORT_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic long_sel,
  output logic expired
);
  localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] LIM_L = W'(LONG_CYC - 1);
  localparam logic [W-1:0] LIM_S = W'(SHORT_CYC - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  assign limit   = long_sel ? LIM_L : LIM_S;
  assign expired = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nib_rx_assemble.sv
module nib_rx_assemble
  import nib_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_lo,
  input  logic       cap_hi,
  input  logic       fault_n,
  input  logic       select,
  input  logic       perror,
  input  logic       busy,
  output logic [7:0] byte_o
);
  logic [3:0] lo_q, hi_q, nib;

  assign nib    = lines_to_nibble(fault_n, select, perror, busy);
  assign byte_o = join_nibbles(hi_q, lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= nib;
      if (cap_hi) hi_q <= nib;
    end
  end
endmodule

// File: rtl/nib_rx_ctrl.sv
module nib_rx_ctrl
  import nib_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] req_count,
  input  logic             ack_n,
  input  logic             expired,
  input  logic             ready,
  output logic             timer_clear,
  output logic             timer_run,
  output logic             long_sel,
  output logic             cap_lo,
  output logic             cap_hi,
  output logic             autofd_n,
  output logic             valid,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] delivered
);
  rx_state_e        state, state_n;
  logic             half;
  logic [CNT_W-1:0] remain;
  logic             fin;
  rx_status_e       fin_st;
  logic             take;

  always_comb begin
    state_n = state;
    fin     = 1'b0;
    fin_st  = RX_OK;
    case (state)
      S_IDLE: if (start) begin
        if (req_count == '0) fin = 1'b1;
        else                 state_n = S_REQ;
      end
      S_REQ: begin
        if (!ack_n) state_n = S_ACK;
        else if (expired) begin
          fin = 1'b1; fin_st = RX_TIMEOUT; state_n = S_IDLE;
        end
      end
      S_ACK: begin
        if (ack_n) state_n = half ? S_HOLD : S_REQ;
        else if (expired) begin
          fin = 1'b1; fin_st = half ? RX_IOERR : RX_TIMEOUT; state_n = S_IDLE;
        end
      end
      S_HOLD: if (ready) begin
        if (remain == CNT_W'(1)) begin
          fin = 1'b1; state_n = S_IDLE;
        end else state_n = S_REQ;
      end
      default: state_n = S_IDLE;
    endcase
  end

  assign take        = (state == S_HOLD) && ready;
  assign timer_run   = (state == S_REQ) || (state == S_ACK);
  assign timer_clear = (state_n != state);
  assign long_sel    = (state == S_REQ) && !half;
  assign cap_lo      = (state == S_REQ) && !ack_n && !half;
  assign cap_hi      = (state == S_REQ) && !ack_n && half;
  assign valid       = (state == S_HOLD);
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      half      <= 1'b0;
      remain    <= '0;
      delivered <= '0;
      autofd_n  <= 1'b1;
      done      <= 1'b0;
      status    <= RX_OK;
    end else begin
      state    <= state_n;
      autofd_n <= (state_n != S_REQ);
      done     <= fin;
      if (fin) status <= fin_st;
      if (state == S_IDLE) begin
        half <= 1'b0;
        if (start) begin
          remain    <= req_count;
          delivered <= '0;
        end
      end else if (state == S_ACK && ack_n && !half) begin
        half <= 1'b1;
      end else if (take) begin
        half      <= 1'b0;
        remain    <= remain - 1'b1;
        delivered <= delivered + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nib_rev_rx.sv
module nib_rev_rx
  import nib_rx_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TICK_CYCLES = 4,
  parameter int unsigned LONG_TICKS  = 2000,
  parameter int unsigned SHORT_TICKS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] req_count_i,
  input  logic             ack_n_i,
  input  logic             busy_i,
  input  logic             perror_i,
  input  logic             select_i,
  input  logic             fault_n_i,
  output logic             autofd_n_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  input  logic             byte_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [CNT_W-1:0] delivered_o
);
  localparam int unsigned LONG_CYC  = window_cycles(LONG_TICKS, TICK_CYCLES);
  localparam int unsigned SHORT_CYC = window_cycles(SHORT_TICKS, TICK_CYCLES);

  // Named internal events, observed by the bound checker
  logic cap_lo_w, cap_hi_w, expired_w;
  logic tmr_clear_w, tmr_run_w, long_sel_w;

  nib_rx_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear_w), .run(tmr_run_w),
    .long_sel(long_sel_w), .expired(expired_w)
  );

  nib_rx_assemble u_asm (
    .clk(clk), .rst_n(rst_n), .cap_lo(cap_lo_w), .cap_hi(cap_hi_w),
    .fault_n(fault_n_i), .select(select_i), .perror(perror_i), .busy(busy_i),
    .byte_o(byte_data_o)
  );

  nib_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .req_count(req_count_i),
    .ack_n(ack_n_i), .expired(expired_w), .ready(byte_ready_i),
    .timer_clear(tmr_clear_w), .timer_run(tmr_run_w), .long_sel(long_sel_w),
    .cap_lo(cap_lo_w), .cap_hi(cap_hi_w), .autofd_n(autofd_n_o),
    .valid(byte_valid_o), .busy(busy_o), .done(done_o), .status(status_o),
    .delivered(delivered_o)
  );
endmodule

// File: rtl/nib_rx_chk.sv
module nib_rx_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             autofd_n_o,
  input logic             ack_n_i,
  input logic             byte_valid_o,
  input logic             byte_ready_i,
  input logic [7:0]       byte_data_o,
  input logic             done_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] delivered_o,
  input logic             cap_lo_w,
  input logic             cap_hi_w,
  input logic             expired_w
);
  // R3: a capture only happens during a request with acknowledge low
  a_r3_capture_in_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lo_w || cap_hi_w) |-> (!ack_n_i && !autofd_n_o));

  // R3: auto-feed rises mid-run only after acknowledge was seen low
  a_r3_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(autofd_n_o) && !done_o) |-> !$past(ack_n_i));

  // R4: a byte is offered only after acknowledge returned high
  a_r4_offer_after_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid_o) |-> $past(ack_n_i));

  // R5: offered byte held until accepted
  a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

  // R6: no request while a byte is pending
  a_r6_no_req_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> autofd_n_o);

  // R7: expiry while still unanswered ends the run
  a_r7_expiry_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_w && !autofd_n_o && ack_n_i) |=> done_o);

  // R9: done is a single-cycle pulse and delivered never falls within a run
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_delivered_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (delivered_o >= $past(delivered_o)));

  // R10: end of run leaves the line released and nothing offered
  a_r10_quiet_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (autofd_n_o && !busy_o && !byte_valid_o));
endmodule

bind nib_rev_rx nib_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .autofd_n_o(autofd_n_o), .ack_n_i(ack_n_i),
  .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i), .byte_data_o(byte_data_o),
  .done_o(done_o), .busy_o(busy_o), .delivered_o(delivered_o),
  .cap_lo_w(cap_lo_w), .cap_hi_w(cap_hi_w), .expired_w(expired_w)
);

// File: tb/sim_nib_rev_rx.sv
`timescale 1ns/1ps
module sim_nib_rev_rx;
  localparam int CNT_W   = 8;
  localparam int LONG_B  = 2000 * 4;
  localparam int SHORT_B = 6 * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] req_count_i = '0;
  logic ack_n_i = 1'b1, busy_i = 1'b0, perror_i = 1'b0, select_i = 1'b0, fault_n_i = 1'b0;
  logic autofd_n_o, byte_valid_o, busy_o, done_o;
  logic [7:0] byte_data_o;
  logic byte_ready_i = 1'b0;
  logic [1:0] status_o;
  logic [CNT_W-1:0] delivered_o;

  int tests = 0, fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  nib_rev_rx u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lo_of(input logic [7:0] b); return b[3:0]; endfunction
  function automatic logic [3:0] hi_of(input logic [7:0] b); return b[7:4]; endfunction

  // nib bit0 -> fault_n, bit1 -> select, bit2 -> perror, bit3 -> busy
  task automatic put_lines(input logic [3:0] n);
    fault_n_i = n[0]; select_i = n[1]; perror_i = n[2]; busy_i = n[3];
  endtask

  task automatic periph_nibble(input logic [3:0] n, input int d1, input int d2);
    while (autofd_n_o) @(negedge clk);
    repeat (d1) @(negedge clk);
    put_lines(n); ack_n_i = 1'b0;
    while (!autofd_n_o) @(negedge clk);
    repeat (d2) @(negedge clk);
    put_lines(4'($urandom)); ack_n_i = 1'b1;
  endtask

  task automatic kick(input int n);
    @(negedge clk); start_i = 1'b1; req_count_i = CNT_W'(n);
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(input int max, output int cyc);
    cyc = 0;
    while (!done_o && cyc < max) begin @(negedge clk); cyc++; end
  endtask

  logic [7:0] sent [0:15];
  logic [7:0] got  [0:15];

  task automatic run_read(input int n, input int pct);
    int got_n = 0, cyc;
    bit stall_bad = 0;
    bit mism = 0;
    for (int i = 0; i < n; i++) sent[i] = 8'($urandom);
    kick(n);
    chk(autofd_n_o == 1'b0, "R2 request after start", autofd_n_o, 0);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          periph_nibble(lo_of(sent[i]), $urandom_range(0, 60), $urandom_range(0, 12));
          periph_nibble(hi_of(sent[i]), $urandom_range(0, 12), $urandom_range(0, 12));
        end
      end
      begin
        while (got_n < n) begin
          @(negedge clk);
          if (done_o) break;
          byte_ready_i = ($urandom_range(0, 99) < pct);
          if (byte_valid_o && !autofd_n_o) stall_bad = 1;
          if (byte_valid_o && byte_ready_i) begin got[got_n] = byte_data_o; got_n++; end
        end
      end
    join
    wait_done(50, cyc);
    byte_ready_i = 1'b0;
    chk(done_o && status_o == 2'd0, "R9 success status", status_o, 0);
    chk(delivered_o == CNT_W'(n), "R9 delivered count", delivered_o, n);
    for (int i = 0; i < n; i++) if (got[i] != sent[i]) mism = 1;
    chk(!mism && got_n == n, "R4 byte assembly (R3 line mapping)", got[0], sent[0]);
    chk(!stall_bad, "R6 no request while stalled", stall_bad, 0);
    @(negedge clk);
    chk(autofd_n_o && !busy_o && !byte_valid_o, "R10 quiet after run", {autofd_n_o, busy_o, byte_valid_o}, 3'b100);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1; tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    void'($urandom(32'd1284));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(autofd_n_o && !byte_valid_o && !busy_o && delivered_o == '0, "R1 reset state",
        {autofd_n_o, byte_valid_o, busy_o}, 3'b100);

    // Directed single byte with step checks
    kick(1);
    chk(autofd_n_o == 1'b0, "R2 first request", autofd_n_o, 0);
    put_lines(4'hA); ack_n_i = 1'b0;
    @(negedge clk);
    chk(autofd_n_o == 1'b1, "R3 release after ack low", autofd_n_o, 1);
    put_lines(4'h3); ack_n_i = 1'b1;
    @(negedge clk);
    chk(autofd_n_o == 1'b0, "R4 second request", autofd_n_o, 0);
    put_lines(4'h5); ack_n_i = 1'b0;
    @(negedge clk);
    chk(byte_valid_o == 1'b0, "R4 not valid before ack high", byte_valid_o, 0);
    ack_n_i = 1'b1; put_lines(4'hF);
    @(negedge clk);
    chk(byte_valid_o && byte_data_o == 8'h5A, "R4 byte value", byte_data_o, 8'h5A);
    start_i = 1'b1; req_count_i = 8'd7;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(byte_valid_o && byte_data_o == 8'h5A, "R5 held while stalled", byte_data_o, 8'h5A);
    chk(autofd_n_o == 1'b1, "R6 no request while stalled", autofd_n_o, 1);
    byte_ready_i = 1'b1;
    @(negedge clk); byte_ready_i = 1'b0;
    chk(done_o && status_o == 2'd0 && delivered_o == 8'd1, "R2 start ignored while busy (R9)",
        delivered_o, 1);
    @(negedge clk);
    chk(!done_o && !busy_o && autofd_n_o, "R10 idle after done", {done_o, busy_o}, 0);

    // Zero count
    kick(0);
    chk(done_o && status_o == 2'd0 && delivered_o == '0, "R9 zero count", status_o, 0);

    // Random reads
    for (int k = 0; k < 6; k++) run_read($urandom_range(1, 8), $urandom_range(20, 100));

    // First-half window expiry (long)
    byte_ready_i = 1'b1;
    kick(1);
    wait_done(LONG_B + 10, cyc);
    chk(done_o && status_o == 2'd1, "R7 first-half timeout status", status_o, 1);
    chk(cyc >= LONG_B - 1 && cyc <= LONG_B + 1, "R7 long window length", cyc, LONG_B);
    @(negedge clk);
    chk(autofd_n_o && !busy_o, "R10 after timeout", autofd_n_o, 1);

    // Second-half window expiry (short)
    kick(1);
    put_lines(4'h1); ack_n_i = 1'b0;
    @(negedge clk); ack_n_i = 1'b1;
    @(negedge clk);
    wait_done(SHORT_B + 10, cyc);
    chk(done_o && status_o == 2'd1, "R7 second-half timeout status", status_o, 1);
    chk(cyc >= SHORT_B - 2 && cyc <= SHORT_B + 1, "R7 short window length", cyc, SHORT_B);

    // Acknowledge stuck low after first half
    @(negedge clk);
    kick(1);
    ack_n_i = 1'b0;
    wait_done(SHORT_B + 10, cyc);
    chk(done_o && status_o == 2'd1, "R8 stuck ack first half", status_o, 1);
    ack_n_i = 1'b1;

    // Acknowledge stuck low after second half
    @(negedge clk);
    kick(1);
    ack_n_i = 1'b0;
    @(negedge clk); ack_n_i = 1'b1;
    @(negedge clk); ack_n_i = 1'b0;
    wait_done(SHORT_B + 10, cyc);
    chk(done_o && status_o == 2'd2, "R8 stuck ack second half io error", status_o, 2);
    chk(delivered_o == '0 && !byte_valid_o, "R8 no byte after io error", delivered_o, 0);
    ack_n_i = 1'b1;
    byte_ready_i = 1'b0;
    repeat (3) @(negedge clk);

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule